// File: doc/BRIEF.md
# Pixel PLL Parameter Selector

This block holds the clock-synthesis part of a video DAC's indexed register space and turns it into the divider settings for a pixel-clock PLL. Software reaches the registers through an index register and a data port. The index can step forward by itself after every data access, which makes block loads fast. A 2-bit clock select from the display controller picks which programmed setting is active at any moment.

The outputs are the VCO divide count, the post-divide factor, the reference divide count and the dot-clock divider. Two integer terms are also provided: the numerator `vco+65` and the denominator `ref*df*dot`. The pixel frequency is then 28.322 MHz times the numerator over the denominator. A separate programmable enable chooses between two sources for the settings. When the enable is clear, a fixed pair of registers supplies them. When it is set, one of four table-driven modes supplies them.

Top module: `pll_param_sel`

## Requirements
- R1: After reset every register reads 0x00 and the outputs are vco_cnt=0, post_df=8, ref_cnt=0, dot_div=1, pll_num=65 and pll_den=0.
- R2: A pulse on idx_wr loads the index from idx_val. While auto_inc is high, each data_wr or data_rd advances the index by one. The index is 16 bits wide and carries on from 0x7FF to 0x800 with no wrap to 0. While auto_inc is low, the index stays where it is.
- R3: Indices 0x00 to 0x3F read back the last byte written to them. Indices from 0x40 upward read as 0x00, and writes to them are dropped.
- R4: When bit 0 of register 0x02 is clear, the setting byte comes from register 0x16 and the reference count comes from bits 4:0 of register 0x15.
- R5: Bits 3:1 of register 0x02 pick the dot divider. Codes 0 to 4 give 1, 2, 4, 8 and 16. Codes 5 to 7 give 1.
- R6: With programming on and register 0x10 bits 2:0 equal to 0 or to 4–7, the active setting is table F[clk_sel] together with the captured F-reference count.
- R7: With programming on and mode 1, the setting byte is M[clk_sel] and the reference count is N[clk_sel].
- R8: With programming on and mode 2, the active setting is F[reg 0x11 bits 3:0] together with the captured F-reference count.
- R9: With programming on and mode 3, the setting byte is M[reg 0x11 bits 2:0] and the reference count is N[reg 0x11 bits 2:0].
- R10: Writes to indices 0x20–0x2F update the tables only while bit 0 of register 0x02 is set. In modes 0 and 2 such a write loads F[index-0x20]. In modes 1 and 3, an even index loads M[(index-0x20)/2] and an odd index loads N[(index-0x20)/2].
- R11: A write to index 0x14 is captured as the F-reference count only when programming is on and the whole of register 0x10 equals 0x00 or 0x02.
- R12: Every setting byte gives vco_cnt from bits 5:0 and post_df = 8 >> bits 7:6. The integer terms are pll_num = vco_cnt+65 and pll_den = ref_cnt*post_df*dot_div.
- R13: The outputs are registered. They change on the first clock edge after the register write lands, and on the first clock edge after clk_sel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the index from idx_val |
| idx_val | input | 16 | New index value |
| data_wr | input | 1 | Write wdata at the current index |
| data_rd | input | 1 | Data read strobe (advances the index) |
| auto_inc | input | 1 | Step the index after each data access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register contents at the current index |
| clk_sel | input | 2 | External clock select |
| vco_cnt | output | 6 | VCO divide count |
| post_df | output | 4 | Post-divide factor (1, 2, 4 or 8) |
| ref_cnt | output | 5 | Reference divide count |
| dot_div | output | 5 | Dot-clock divider (1 to 16) |
| pll_num | output | 8 | vco_cnt + 65 |
| pll_den | output | 12 | ref_cnt * post_df * dot_div |

## Verification
The hardest behaviour to show from the ports is a table capture that was suppressed. The F, M and N tables and the F-reference count cannot be read back; only the raw register bytes can. The stimulus therefore writes table and reference values while the capture conditions are false: programming off, or register 0x10 at 0x08. It then turns programming on, selects the affected entry, and checks that the outputs still show the earlier contents. The no-wrap index is shown the same way. The bench writes across 0x7FF and then confirms that register 0x00 was not overwritten.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int VCO_W = 6;
  localparam int REF_W = 5;
  localparam int DF_W  = 4;
  localparam int DOT_W = 5;
  localparam int NUM_W = 8;
  localparam int DEN_W = 12;
  localparam int F_CNT  = 16;
  localparam int MN_CNT = 8;
  localparam int VCO_BIAS = 65;

  localparam logic [7:0] A_CTRL   = 8'h02;
  localparam logic [7:0] A_MODE   = 8'h10;
  localparam logic [7:0] A_FSEL   = 8'h11;
  localparam logic [7:0] A_FREF   = 8'h14;
  localparam logic [7:0] A_FIXREF = 8'h15;
  localparam logic [7:0] A_FIXVCO = 8'h16;
  localparam logic [7:0] A_TBL    = 8'h20;

  localparam logic [2:0] M_F_EXT  = 3'd0;
  localparam logic [2:0] M_MN_EXT = 3'd1;
  localparam logic [2:0] M_F_REG  = 3'd2;
  localparam logic [2:0] M_MN_REG = 3'd3;

  typedef struct packed {
    logic [VCO_W-1:0] vco;
    logic [DF_W-1:0]  df;
    logic [REF_W-1:0] rc;
    logic [DOT_W-1:0] dot;
  } pll_set_t;

  function automatic logic [DF_W-1:0] df_of(input logic [1:0] code);
    return DF_W'(4'b1000 >> code);
  endfunction

  function automatic logic [DOT_W-1:0] dot_of(input logic [2:0] code);
    logic [DOT_W-1:0] r;
    case (code)
      3'd1:    r = DOT_W'(2);
      3'd2:    r = DOT_W'(4);
      3'd3:    r = DOT_W'(8);
      3'd4:    r = DOT_W'(16);
      default: r = DOT_W'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pps_regfile.sv
module pps_regfile
  import pps_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic             auto_inc,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [IDX_W-1:0] cur_idx,
  output logic             prog_en,
  output logic [2:0]       dot_code,
  output logic [7:0]       mode_b,
  output logic [3:0]       fsel,
  output logic [7:0]       fix_vco,
  output logic [REF_W-1:0] fix_ref
);
  localparam int AW = $clog2(DEPTH);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       mem_d [DEPTH];
  logic             in_win;
  logic [AW-1:0]    slot;
  logic             idx_en, mem_en;

  assign in_win = (idx_q < IDX_W'(DEPTH));
  assign slot   = idx_q[AW-1:0];

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (idx_wr) begin
      idx_d  = idx_val;
      idx_en = 1'b1;
    end else if ((data_wr || data_rd) && auto_inc) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_comb begin
    mem_d  = mem_q;
    mem_en = data_wr && in_win;
    if (mem_en) mem_d[slot] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  assign rdata    = in_win ? mem_q[slot] : 8'h00;
  assign cur_idx  = idx_q;
  assign prog_en  = mem_q[A_CTRL[AW-1:0]][0];
  assign dot_code = mem_q[A_CTRL[AW-1:0]][3:1];
  assign mode_b   = mem_q[A_MODE[AW-1:0]];
  assign fsel     = mem_q[A_FSEL[AW-1:0]][3:0];
  assign fix_vco  = mem_q[A_FIXVCO[AW-1:0]];
  assign fix_ref  = mem_q[A_FIXREF[AW-1:0]][REF_W-1:0];
endmodule

// File: rtl/pps_shadow.sv
module pps_shadow
  import pps_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          data_wr,
  input  logic [IDX_W-1:0]              cur_idx,
  input  logic [7:0]                    wdata,
  input  logic                          prog_en,
  input  logic [7:0]                    mode_b,
  output logic [F_CNT-1:0][7:0]         f_q,
  output logic [MN_CNT-1:0][7:0]        m_q,
  output logic [MN_CNT-1:0][REF_W-1:0]  n_q,
  output logic [REF_W-1:0]              fref_q
);
  localparam int OFF_W = $clog2(F_CNT);

  logic [F_CNT-1:0][7:0]        f_d;
  logic [MN_CNT-1:0][7:0]       m_d;
  logic [MN_CNT-1:0][REF_W-1:0] n_d;
  logic [REF_W-1:0]             fref_d;
  logic tbl_hit, f_mode, mn_mode, fref_hit;
  logic f_en, mn_en, fref_en;
  logic [OFF_W-1:0] off;

  assign off      = cur_idx[OFF_W-1:0];
  assign tbl_hit  = data_wr && prog_en &&
                    (cur_idx[IDX_W-1:OFF_W] == (IDX_W-OFF_W)'(A_TBL >> OFF_W));
  assign f_mode   = (mode_b[2:0] == M_F_EXT) || (mode_b[2:0] == M_F_REG);
  assign mn_mode  = (mode_b[2:0] == M_MN_EXT) || (mode_b[2:0] == M_MN_REG);
  assign fref_hit = data_wr && prog_en && (cur_idx == IDX_W'(A_FREF)) &&
                    ((mode_b == 8'h00) || (mode_b == 8'h02));

  always_comb begin
    f_d    = f_q;
    m_d    = m_q;
    n_d    = n_q;
    fref_d = fref_q;
    f_en   = tbl_hit && f_mode;
    mn_en  = tbl_hit && mn_mode;
    fref_en = fref_hit;
    if (f_en) f_d[off] = wdata;
    if (mn_en) begin
      if (off[0]) n_d[off[OFF_W-1:1]] = wdata[REF_W-1:0];
      else        m_d[off[OFF_W-1:1]] = wdata;
    end
    if (fref_en) fref_d = wdata[REF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else if (f_en) f_q <= f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
    end else if (mn_en) begin
      m_q <= m_d;
      n_q <= n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fref_q <= '0;
    else if (fref_en) fref_q <= fref_d;
  end
endmodule

// File: rtl/pps_select.sv
module pps_select
  import pps_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_en,
  input  logic [2:0]                    mode,
  input  logic [3:0]                    fsel,
  input  logic [2:0]                    dot_code,
  input  logic [7:0]                    fix_vco,
  input  logic [REF_W-1:0]              fix_ref,
  input  logic [F_CNT-1:0][7:0]         f_q,
  input  logic [MN_CNT-1:0][7:0]        m_q,
  input  logic [MN_CNT-1:0][REF_W-1:0]  n_q,
  input  logic [REF_W-1:0]              fref_q,
  input  logic [1:0]                    csel,
  output logic [VCO_W-1:0]              vco_cnt,
  output logic [DF_W-1:0]               post_df,
  output logic [REF_W-1:0]              ref_cnt,
  output logic [DOT_W-1:0]              dot_div,
  output logic [NUM_W-1:0]              pll_num,
  output logic [DEN_W-1:0]              pll_den
);
  logic [7:0]       vb;
  logic [REF_W-1:0] rb;
  pll_set_t         set_d, set_q;
  logic [NUM_W-1:0] num_d, num_q;
  logic [DEN_W-1:0] den_d, den_q;

  always_comb begin
    vb = fix_vco;
    rb = fix_ref;
    if (prog_en) begin
      case (mode)
        M_MN_EXT: begin
          vb = m_q[{1'b0, csel}];
          rb = n_q[{1'b0, csel}];
        end
        M_F_REG: begin
          vb = f_q[fsel];
          rb = fref_q;
        end
        M_MN_REG: begin
          vb = m_q[fsel[2:0]];
          rb = n_q[fsel[2:0]];
        end
        default: begin
          vb = f_q[{2'b00, csel}];
          rb = fref_q;
        end
      endcase
    end
  end

  always_comb begin
    set_d.vco = vb[VCO_W-1:0];
    set_d.df  = df_of(vb[7:6]);
    set_d.rc  = rb;
    set_d.dot = dot_of(dot_code);
    num_d = NUM_W'(set_d.vco) + NUM_W'(VCO_BIAS);
    den_d = DEN_W'(set_d.rc) * DEN_W'(set_d.df) * DEN_W'(set_d.dot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '{vco: '0, df: DF_W'(8), rc: '0, dot: DOT_W'(1)};
      num_q <= NUM_W'(VCO_BIAS);
      den_q <= '0;
    end else begin
      set_q <= set_d;
      num_q <= num_d;
      den_q <= den_d;
    end
  end

  assign vco_cnt = set_q.vco;
  assign post_df = set_q.df;
  assign ref_cnt = set_q.rc;
  assign dot_div = set_q.dot;
  assign pll_num = num_q;
  assign pll_den = den_q;
endmodule

// File: rtl/pll_param_sel.sv
module pll_param_sel
  import pps_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic             auto_inc,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [1:0]       clk_sel,
  output logic [VCO_W-1:0] vco_cnt,
  output logic [DF_W-1:0]  post_df,
  output logic [REF_W-1:0] ref_cnt,
  output logic [DOT_W-1:0] dot_div,
  output logic [NUM_W-1:0] pll_num,
  output logic [DEN_W-1:0] pll_den
);
  logic [IDX_W-1:0]             cur_idx;
  logic                         prog_en;
  logic [2:0]                   dot_code;
  logic [7:0]                   mode_b;
  logic [3:0]                   fsel;
  logic [7:0]                   fix_vco;
  logic [REF_W-1:0]             fix_ref;
  logic [F_CNT-1:0][7:0]        f_q;
  logic [MN_CNT-1:0][7:0]       m_q;
  logic [MN_CNT-1:0][REF_W-1:0] n_q;
  logic [REF_W-1:0]             fref_q;

  pps_regfile #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .data_wr(data_wr), .data_rd(data_rd), .auto_inc(auto_inc),
    .wdata(wdata), .rdata(rdata), .cur_idx(cur_idx), .prog_en(prog_en),
    .dot_code(dot_code), .mode_b(mode_b), .fsel(fsel),
    .fix_vco(fix_vco), .fix_ref(fix_ref)
  );

  pps_shadow #(.IDX_W(IDX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .cur_idx(cur_idx),
    .wdata(wdata), .prog_en(prog_en), .mode_b(mode_b),
    .f_q(f_q), .m_q(m_q), .n_q(n_q), .fref_q(fref_q)
  );

  pps_select u_sel (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mode(mode_b[2:0]),
    .fsel(fsel), .dot_code(dot_code), .fix_vco(fix_vco), .fix_ref(fix_ref),
    .f_q(f_q), .m_q(m_q), .n_q(n_q), .fref_q(fref_q), .csel(clk_sel),
    .vco_cnt(vco_cnt), .post_df(post_df), .ref_cnt(ref_cnt),
    .dot_div(dot_div), .pll_num(pll_num), .pll_den(pll_den)
  );
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_wr,
  input logic [IDX_W-1:0] idx_val,
  input logic             data_wr,
  input logic             data_rd,
  input logic             auto_inc,
  input logic [1:0]       clk_sel,
  input logic [IDX_W-1:0] cur_idx,
  input logic [5:0]       vco_cnt,
  input logic [3:0]       post_df,
  input logic [4:0]       ref_cnt,
  input logic [4:0]       dot_div
);
  logic prev_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_wr <= 1'b1;
    else        prev_wr <= data_wr;
  end

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> cur_idx == $past(idx_val));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && (data_wr || data_rd) && auto_inc) |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !(auto_inc && (data_wr || data_rd))) |=> $stable(cur_idx));

  // R12
  df_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(post_df) == 1);

  // R5
  dot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dot_div) == 1);

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_wr && $stable(clk_sel)) |=> ($stable(vco_cnt) && $stable(post_df) &&
                                        $stable(ref_cnt) && $stable(dot_div)));
endmodule

bind pll_param_sel pps_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
  .data_wr(data_wr), .data_rd(data_rd), .auto_inc(auto_inc),
  .clk_sel(clk_sel), .cur_idx(cur_idx), .vco_cnt(vco_cnt),
  .post_df(post_df), .ref_cnt(ref_cnt), .dot_div(dot_div)
);

// File: tb/pll_param_sel_tb.sv
module pll_param_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [15:0] idx_val = '0;
  logic        data_wr = 1'b0;
  logic        data_rd = 1'b0;
  logic        auto_inc = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  clk_sel = '0;
  logic [5:0]  vco_cnt;
  logic [3:0]  post_df;
  logic [4:0]  ref_cnt;
  logic [4:0]  dot_div;
  logic [7:0]  pll_num;
  logic [11:0] pll_den;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pll_param_sel u_dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .data_wr(data_wr), .data_rd(data_rd), .auto_inc(auto_inc),
    .wdata(wdata), .rdata(rdata), .clk_sel(clk_sel), .vco_cnt(vco_cnt),
    .post_df(post_df), .ref_cnt(ref_cnt), .dot_div(dot_div),
    .pll_num(pll_num), .pll_den(pll_den)
  );

  typedef struct packed {
    logic [7:0] ctl;
    logic [7:0] mode;
    logic [7:0] fsel;
    logic [1:0] cs;
    logic [5:0] vco;
    logic [3:0] df;
    logic [4:0] rc;
    logic [4:0] dot;
    logic [3:0] req;
  } vec_t;

  // R4 R5 R6 R7 R8 R9 vectors
  localparam vec_t TBL [16] = '{
    '{8'h01, 8'h00, 8'h00, 2'd2,  6'd3, 4'd2, 5'd7, 5'd1,  4'd6},
    '{8'h01, 8'h00, 8'h00, 2'd3,  6'd4, 4'd1, 5'd7, 5'd1,  4'd6},
    '{8'h01, 8'h05, 8'h00, 2'd1,  6'd2, 4'd4, 5'd7, 5'd1,  4'd6},
    '{8'h01, 8'h01, 8'h00, 2'd1, 6'd21, 4'd4, 5'd4, 5'd1,  4'd7},
    '{8'h01, 8'h01, 8'h00, 2'd3, 6'd23, 4'd1, 5'd6, 5'd1,  4'd7},
    '{8'h01, 8'h02, 8'h0B, 2'd0, 6'd12, 4'd1, 5'd7, 5'd1,  4'd8},
    '{8'h01, 8'h02, 8'h1E, 2'd1, 6'd15, 4'd2, 5'd7, 5'd1,  4'd8},
    '{8'h01, 8'h03, 8'h0D, 2'd0, 6'd25, 4'd4, 5'd8, 5'd1,  4'd9},
    '{8'h01, 8'h03, 8'h06, 2'd2, 6'd26, 4'd2, 5'd9, 5'd1,  4'd9},
    '{8'h00, 8'h03, 8'h00, 2'd2, 6'd33, 4'd4, 5'd9, 5'd1,  4'd4},
    '{8'h03, 8'h00, 8'h00, 2'd0,  6'd1, 4'd8, 5'd7, 5'd2,  4'd5},
    '{8'h05, 8'h00, 8'h00, 2'd1,  6'd2, 4'd4, 5'd7, 5'd4,  4'd5},
    '{8'h07, 8'h00, 8'h00, 2'd2,  6'd3, 4'd2, 5'd7, 5'd8,  4'd5},
    '{8'h09, 8'h00, 8'h00, 2'd3,  6'd4, 4'd1, 5'd7, 5'd16, 4'd5},
    '{8'h0F, 8'h00, 8'h00, 2'd0,  6'd1, 4'd8, 5'd7, 5'd1,  4'd5},
    '{8'h0E, 8'h00, 8'h00, 2'd0, 6'd33, 4'd4, 5'd9, 5'd1,  4'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_out();
    return {5'd0, vco_cnt, post_df, ref_cnt, dot_div, pll_num[6:0]};
  endfunction

  function automatic logic [31:0] pack_exp(input logic [5:0] v, input logic [3:0] d,
                                           input logic [4:0] r, input logic [4:0] t);
    logic [7:0] n;
    n = 8'(v) + 8'd65;
    return {5'd0, v, d, r, t, n[6:0]};
  endfunction

  task automatic check_set(input string req, input logic [5:0] v, input logic [3:0] d,
                           input logic [4:0] r, input logic [4:0] t);
    check(req, pack_out(), pack_exp(v, d, r, t));
    // R12 denominator
    check("R12", 32'(pll_den), 32'(r) * 32'(d) * 32'(t));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; idx_val = a;
    @(negedge clk); idx_wr = 1'b0; data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic set_idx(input logic [15:0] a);
    @(negedge clk); idx_wr = 1'b1; idx_val = a;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] v);
    data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    set_idx(a);
    v = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_set("R1", 6'd0, 4'd8, 5'd0, 5'd1);
    check("R1", 32'(pll_den), 32'd0);
    check("R1", 32'(rdata), 32'h00);

    // load tables: F first, then M/N
    wr(16'h02, 8'h01);
    wr(16'h10, 8'h00);
    wr(16'h14, 8'h07);
    set_idx(16'h20);
    for (int i = 0; i < 16; i++) put(8'(((i % 4) << 6) | (i + 1)));
    wr(16'h10, 8'h01);
    set_idx(16'h20);
    for (int k = 0; k < 8; k++) begin
      put(8'(((k % 4) << 6) | (k + 20)));
      put(8'(k + 3));
    end
    wr(16'h15, 8'h09);
    wr(16'h16, 8'h61);

    for (int e = 0; e < 16; e++) begin
      wr(16'h02, TBL[e].ctl);
      wr(16'h10, TBL[e].mode);
      wr(16'h11, TBL[e].fsel);
      @(negedge clk); clk_sel = TBL[e].cs;
      settle();
      check_set($sformatf("R%0d vec%0d", TBL[e].req, e),
                TBL[e].vco, TBL[e].df, TBL[e].rc, TBL[e].dot);
    end

    // R11: reference capture blocked when register 0x10 is 0x08
    wr(16'h02, 8'h01);
    wr(16'h10, 8'h08);
    wr(16'h14, 8'h1F);
    wr(16'h10, 8'h00);
    @(negedge clk); clk_sel = 2'd0;
    settle();
    check_set("R11 blocked", 6'd1, 4'd8, 5'd7, 5'd1);
    wr(16'h10, 8'h02);
    wr(16'h14, 8'h0A);
    wr(16'h11, 8'h00);
    settle();
    check_set("R11 captured", 6'd1, 4'd8, 5'd10, 5'd1);

    // R10: table write ignored while programming is off
    wr(16'h02, 8'h00);
    wr(16'h10, 8'h00);
    wr(16'h22, 8'hFF);
    wr(16'h02, 8'h01);
    @(negedge clk); clk_sel = 2'd2;
    settle();
    check_set("R10", 6'd3, 4'd2, 5'd10, 5'd1);
    rd(16'h22, v);
    check("R3 raw table byte", 32'(v), 32'hFF);

    // R13: clock select takes effect on the next edge
    @(negedge clk); clk_sel = 2'd1;
    #1 check("R13 before edge", 32'(vco_cnt), 32'd3);
    @(negedge clk);
    check("R13 after edge", 32'(vco_cnt), 32'd2);
    // R13: write lands on one edge, output follows on the next
    set_idx(16'h02);
    put(8'h03);
    check("R13 write pending", 32'(dot_div), 32'd1);
    @(negedge clk);
    check("R13 write applied", 32'(dot_div), 32'd2);

    // R3: readback and out-of-window
    wr(16'h05, 8'hA5);
    rd(16'h05, v);
    check("R3 readback", 32'(v), 32'hA5);
    wr(16'h40, 8'h77);
    rd(16'h40, v);
    check("R3 out of window", 32'(v), 32'h00);

    // R2: auto-increment on writes and reads
    auto_inc = 1'b1;
    set_idx(16'h30);
    put(8'h11); put(8'h22); put(8'h33);
    set_idx(16'h30);
    check("R2 rd0", 32'(rdata), 32'h11);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    check("R2 rd1", 32'(rdata), 32'h22);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    check("R2 rd2", 32'(rdata), 32'h33);
    // R2: no step with auto_inc low
    auto_inc = 1'b0;
    set_idx(16'h34);
    put(8'h44); put(8'h55);
    auto_inc = 1'b1;
    rd(16'h34, v);
    check("R2 hold overwrite", 32'(v), 32'h55);
    rd(16'h35, v);
    check("R2 hold neighbour", 32'(v), 32'h00);
    // R2: index runs past 0x7FF without wrapping to 0
    set_idx(16'h07FF);
    put(8'h5A); put(8'h5A);
    rd(16'h00, v);
    check("R2 no wrap", 32'(v), 32'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule